// File: doc/BRIEF.md
# Up/Down Timer with Capture and Compare

This block is a 16-bit counter that can count up or down, paced by an 8-bit prescaler. A small byte-wide register bus configures it. One control/status byte enables counting, selects automatic clearing on capture or on compare, clears the counter from software and sets the count direction. The same byte reports the direction actually in use, a wrap-during-capture flag and whether the counter is running.

Two capture registers each latch the counter value on a rising edge of their own trigger input. A compare register produces a match event when the counter is about to step away from the programmed value. Capture, compare and counter wrap each raise a one-cycle interrupt-request pulse. Counting runs only when both the local enable bit and a chip-level enable input are high. Capture keeps working while counting is stopped. A hardware direction input, qualified by a valid flag, overrides the software direction bit.

Top module: `updown_capture_timer`

## Requirements
- R1: After reset the control byte reads 00h, the compare value reads FFFFh, both capture values and the prescaler reload read 0000h/00h, and all interrupt outputs are low.
- R2: The counter and prescaler advance only while control bit 7 and `glob_en_i` are both 1. The prescaler counts down from its reload value, and the counter takes one step in the cycle in which the prescaler is at zero, so it steps once every reload+1 cycles.
- R3: Setting bit 7 resumes counting from the counter's present value. Neither the counter nor the prescaler is reloaded.
- R4: A rising edge on `trig_i[n]` copies the counter into capture register n at that clock edge, whether or not the counter is running. `irq_cap_o` is high for the following cycle.
- R5: With control bit 6 set, a capture event on either channel clears the counter to 0 and reloads the prescaler instead of letting it step.
- R6: When a count step is due and the counter equals the compare value, `irq_cmp_o` pulses in the next cycle. With control bit 5 set, the counter goes to 0 instead of stepping and the prescaler reloads.
- R7: Writing 1 to control bit 4 clears the counter and reloads the prescaler without any interrupt pulse. If a step is due in the same cycle, the clear wins. Bit 4 always reads 0.
- R8: Control bit 3 selects the direction (1 = up, 0 = down) while `dir_hw_valid_i` is 0. While it is 1, `dir_hw_up_i` selects the direction. Read-only bit 2 shows the direction in effect.
- R9: An up step from FFFFh to 0000h, or a down step from 0000h to FFFFh, pulses `irq_ovf_o` for one cycle.
- R10: Read-only bit 1 is set when a capture into register 0 happens and a wrap has occurred since the previous capture into register 0 (or in the same cycle). Reading address 0 or address 4 clears it. A set in the same cycle wins over the clear.
- R11: Read-only bit 0 reads 1 exactly while bit 7 and `glob_en_i` are both 1.
- R12: Register map, read combinationally: 0 control/status, 1 prescaler reload, 2/3 compare low/high byte, 4/5 capture 0 low/high byte, 6/7 capture 1 low/high byte. Addresses 4 to 7 are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en_i | input | 1 | Chip-level count enable |
| dir_hw_valid_i | input | 1 | Hardware direction override is valid |
| dir_hw_up_i | input | 1 | Hardware direction: 1 up, 0 down |
| trig_i | input | 2 | Capture triggers, one per capture register |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears the wrap flag on addresses 0 and 4) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| irq_cap_o | output | 1 | Capture interrupt pulse |
| irq_cmp_o | output | 1 | Compare-match interrupt pulse |
| irq_ovf_o | output | 1 | Overflow/underflow interrupt pulse |

## Verification
The assertions check, on every cycle:
- that the counter holds still when no step or clear is due;
- that any clear lands on zero;
- the wrap values and the single-cycle overflow pulse;
- the prescaler reload after a step;
- that each capture register takes the counter value at its trigger edge;
- that the wrap flag only rises after a capture into register 0 and falls after a clearing read.

Only the bench scenarios can show the exact count reached after a given number of cycles for each reload value, the interaction of the two enables, and the direction override. They also cover the clear-on-capture and clear-on-compare periods, and the strict order and absence of interrupt pulses, which a scoreboard tracks across the whole run.

// File: rtl/utc_pkg.sv
package utc_pkg;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned PSC_W  = 8;
    localparam int unsigned NCAP   = 2;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAP0_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_CAP0_HI = 3'd5;
    localparam logic [ADDR_W-1:0] A_CAP1_LO = 3'd6;
    localparam logic [ADDR_W-1:0] A_CAP1_HI = 3'd7;

    localparam int B_CEN  = 7;
    localparam int B_CCP  = 6;
    localparam int B_CCMP = 5;
    localparam int B_CCL  = 4;
    localparam int B_UDC  = 3;

    typedef struct packed {
        logic cen;
        logic ccp;
        logic ccmp;
        logic udc;
    } ctrl_cfg_t;
endpackage

// File: rtl/utc_prescaler.sv
module utc_prescaler
    import utc_pkg::*;
#(
    parameter int unsigned W = PSC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         reload_i,
    input  logic [W-1:0] reload_val_i,
    output logic         tick_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } psc_st_t;

    psc_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = run_i && (st_q.cnt == '0);
        if (reload_i) begin
            st_d.cnt = reload_val_i;
        end else if (run_i) begin
            if (st_q.cnt == '0) st_d.cnt = reload_val_i;
            else                st_d.cnt = st_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: after a step the prescaler restarts from the reload value
    a_r2_psc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !reload_i) |=> (st_q.cnt == $past(reload_val_i)));

    // R2: a stopped prescaler without reload keeps its value
    a_r2_psc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !reload_i) |=> $stable(st_q.cnt));
endmodule

// File: rtl/utc_counter.sv
module utc_counter
    import utc_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         up_i,
    input  logic         clr_i,
    input  logic [W-1:0] cmp_val_i,
    input  logic         cmp_clr_en_i,
    output logic [W-1:0] cnt_o,
    output logic         clr_all_o,
    output logic         wrap_o,
    output logic         irq_cmp_o,
    output logic         irq_ovf_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         irq_cmp;
        logic         irq_ovf;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    hit;
    logic    at_edge;

    always_comb begin
        st_d      = st_q;
        hit       = tick_i && (st_q.cnt == cmp_val_i);
        clr_all_o = clr_i || (hit && cmp_clr_en_i);
        at_edge   = up_i ? (&st_q.cnt) : (st_q.cnt == '0);
        wrap_o    = tick_i && !clr_all_o && at_edge;

        if (clr_all_o)  st_d.cnt = '0;
        else if (tick_i) st_d.cnt = up_i ? st_q.cnt + W'(1) : st_q.cnt - W'(1);

        st_d.irq_cmp = hit;
        st_d.irq_ovf = wrap_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign irq_cmp_o = st_q.irq_cmp;
    assign irq_ovf_o = st_q.irq_ovf;

    // R7 / R5: any clear request lands on zero, beating a due step
    a_r7_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0));

    // R2: no step and no clear means the count holds
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_all_o) |=> $stable(st_q.cnt));

    // R9: overflow request is a single-cycle pulse
    a_r9_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf_o |=> !irq_ovf_o);

    // R9: wrap values
    a_r9_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && up_i) |=> (st_q.cnt == '0));
    a_r9_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !up_i) |=> (&st_q.cnt));
endmodule

// File: rtl/utc_capture.sv
module utc_capture
    import utc_pkg::*;
#(
    parameter int unsigned W = CNT_W,
    parameter int unsigned N = NCAP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        trig_i,
    input  logic [W-1:0]        cnt_i,
    output logic [N-1:0]        evt_o,
    output logic [N-1:0][W-1:0] cap_o,
    output logic                irq_cap_o
);
    typedef struct packed {
        logic [N-1:0]        prev;
        logic [N-1:0][W-1:0] cap;
        logic                irq;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        evt_o     = trig_i & ~st_q.prev;
        st_d.prev = trig_i;
        for (int i = 0; i < int'(N); i++) begin
            if (evt_o[i]) st_d.cap[i] = cnt_i;
        end
        st_d.irq = |evt_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o     = st_q.cap;
    assign irq_cap_o = st_q.irq;

    // R4: a capture event raises the request in the next cycle
    a_r4_cap_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_o) |=> irq_cap_o);

    for (genvar g = 0; g < int'(N); g++) begin : g_chk
        // R4: each channel holds the count seen at its trigger edge
        a_r4_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
            evt_o[g] |=> (cap_o[g] == $past(cnt_i)));
        a_r4_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !evt_o[g] |=> $stable(cap_o[g]));
    end
endmodule

// File: rtl/utc_regs.sv
module utc_regs
    import utc_pkg::*;
#(
    parameter int unsigned W  = CNT_W,
    parameter int unsigned PW = PSC_W,
    parameter int unsigned N  = NCAP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [7:0]          wdata_i,
    input  logic                dir_up_i,
    input  logic                run_i,
    input  logic                wrap_i,
    input  logic                cap0_evt_i,
    input  logic [N-1:0][W-1:0] cap_i,
    output ctrl_cfg_t           cfg_o,
    output logic                soft_clr_o,
    output logic [PW-1:0]       reload_o,
    output logic [W-1:0]        cmp_o,
    output logic [7:0]          rdata_o
);
    typedef struct packed {
        ctrl_cfg_t     cfg;
        logic [PW-1:0] reload;
        logic [W-1:0]  cmp;
        logic          flag;
        logic          wrap_pend;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    rd_clr;

    always_comb begin
        st_d       = st_q;
        soft_clr_o = wr_i && (addr_i == A_CTRL) && wdata_i[B_CCL];
        rd_clr     = rd_i && ((addr_i == A_CTRL) || (addr_i == A_CAP0_LO));

        if (wr_i) begin
            case (addr_i)
                A_CTRL: begin
                    st_d.cfg.cen  = wdata_i[B_CEN];
                    st_d.cfg.ccp  = wdata_i[B_CCP];
                    st_d.cfg.ccmp = wdata_i[B_CCMP];
                    st_d.cfg.udc  = wdata_i[B_UDC];
                end
                A_RELOAD: st_d.reload   = wdata_i;
                A_CMP_LO: st_d.cmp[7:0] = wdata_i;
                A_CMP_HI: st_d.cmp[W-1:8] = wdata_i;
                default: ;
            endcase
        end

        if (cap0_evt_i) begin
            st_d.flag      = st_q.flag || st_q.wrap_pend || wrap_i;
            st_d.wrap_pend = 1'b0;
        end else begin
            st_d.wrap_pend = st_q.wrap_pend || wrap_i;
            if (rd_clr) st_d.flag = 1'b0;
        end

        case (addr_i)
            A_CTRL:    rdata_o = {st_q.cfg.cen, st_q.cfg.ccp, st_q.cfg.ccmp, 1'b0,
                                  st_q.cfg.udc, dir_up_i, st_q.flag, run_i};
            A_RELOAD:  rdata_o = st_q.reload;
            A_CMP_LO:  rdata_o = st_q.cmp[7:0];
            A_CMP_HI:  rdata_o = st_q.cmp[W-1:8];
            A_CAP0_LO: rdata_o = cap_i[0][7:0];
            A_CAP0_HI: rdata_o = cap_i[0][W-1:8];
            A_CAP1_LO: rdata_o = cap_i[1][7:0];
            default:   rdata_o = cap_i[1][W-1:8];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cmp <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o    = st_q.cfg;
    assign reload_o = st_q.reload;
    assign cmp_o    = st_q.cmp;

    // R10: the flag can only rise through a capture into register 0
    a_r10_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(cap0_evt_i));

    // R10: a clearing read without a capture leaves the flag low
    a_r10_flag_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !cap0_evt_i) |=> !st_q.flag);
endmodule

// File: rtl/updown_capture_timer.sv
module updown_capture_timer
    import utc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        glob_en_i,
    input  logic        dir_hw_valid_i,
    input  logic        dir_hw_up_i,
    input  logic [1:0]  trig_i,
    input  logic        reg_wr_i,
    input  logic        reg_rd_i,
    input  logic [2:0]  reg_addr_i,
    input  logic [7:0]  reg_wdata_i,
    output logic [7:0]  reg_rdata_o,
    output logic        irq_cap_o,
    output logic        irq_cmp_o,
    output logic        irq_ovf_o
);
    ctrl_cfg_t                     cfg;
    logic                          soft_clr;
    logic [PSC_W-1:0]              reload_val;
    logic [CNT_W-1:0]              cmp_val;
    logic [CNT_W-1:0]              cnt;
    logic [NCAP-1:0]               cap_evt;
    logic [NCAP-1:0][CNT_W-1:0]    cap_val;
    logic                          run;
    logic                          dir_up;
    logic                          tick;
    logic                          clr_ext;
    logic                          clr_all;
    logic                          wrap;

    always_comb begin
        run     = cfg.cen && glob_en_i;
        dir_up  = dir_hw_valid_i ? dir_hw_up_i : cfg.udc;
        clr_ext = soft_clr || (cfg.ccp && (|cap_evt));
    end

    utc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .rd_i       (reg_rd_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .dir_up_i   (dir_up),
        .run_i      (run),
        .wrap_i     (wrap),
        .cap0_evt_i (cap_evt[0]),
        .cap_i      (cap_val),
        .cfg_o      (cfg),
        .soft_clr_o (soft_clr),
        .reload_o   (reload_val),
        .cmp_o      (cmp_val),
        .rdata_o    (reg_rdata_o)
    );

    utc_prescaler u_psc (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .reload_i     (clr_all),
        .reload_val_i (reload_val),
        .tick_o       (tick)
    );

    utc_counter u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .up_i         (dir_up),
        .clr_i        (clr_ext),
        .cmp_val_i    (cmp_val),
        .cmp_clr_en_i (cfg.ccmp),
        .cnt_o        (cnt),
        .clr_all_o    (clr_all),
        .wrap_o       (wrap),
        .irq_cmp_o    (irq_cmp_o),
        .irq_ovf_o    (irq_ovf_o)
    );

    utc_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig_i),
        .cnt_i     (cnt),
        .evt_o     (cap_evt),
        .cap_o     (cap_val),
        .irq_cap_o (irq_cap_o)
    );

    // R7: a software clear never produces an overflow request
    a_r7_clear_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> !irq_ovf_o);

    // R2: with the global enable low the counter cannot step
    a_r2_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en_i |-> !tick);
endmodule

// File: tb/updown_capture_timer_tb_top.sv
module updown_capture_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glob_en = 1'b1;
    logic       hw_valid = 1'b0;
    logic       hw_up = 1'b0;
    logic [1:0] trig = 2'b00;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_cap, irq_cmp, irq_ovf;

    int checks = 0;
    int failures = 0;
    logic [2:0] exp_q[$];   // expected irq patterns {cap, cmp, ovf}

    localparam logic [7:0] CEN = 8'h80, CCP = 8'h40, CCMP = 8'h20, CCL = 8'h10, UDC = 8'h08;

    always #10 clk = ~clk;

    updown_capture_timer dut_i (
        .clk(clk), .rst_n(rst_n), .glob_en_i(glob_en), .dir_hw_valid_i(hw_valid),
        .dir_hw_up_i(hw_up), .trig_i(trig), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_cap_o(irq_cap), .irq_cmp_o(irq_cmp), .irq_ovf_o(irq_ovf)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd_reg(a, lo);
        rd_reg(a + 3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic capture(input int ch);
        exp_q.push_back(3'b100);
        trig[ch] = 1'b1;
        @(negedge clk);
        trig[ch] = 1'b0;
        @(negedge clk);
    endtask

    // clear and start at edge E, stop at edge E+m: count = m/(r+1) steps
    task automatic run_count(input logic [7:0] r, input int m, input logic [7:0] bits);
        wr_reg(3'd1, r);
        wr_reg(3'd0, CEN | CCL | bits);
        repeat (m - 1) @(negedge clk);
        wr_reg(3'd0, bits);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (irq_cap || irq_cmp || irq_ovf)) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R4/R6/R7/R9 unexpected irq actual=%b expected=none",
                         {irq_cap, irq_cmp, irq_ovf});
            end else begin
                logic [2:0] e;
                e = exp_q.pop_front();
                if ({irq_cap, irq_cmp, irq_ovf} !== e) begin
                    failures++;
                    $display("FAIL R4/R6/R9 irq pattern actual=%b expected=%b",
                             {irq_cap, irq_cmp, irq_ovf}, e);
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irqs", {13'd0, irq_cap, irq_cmp, irq_ovf}, 16'h0);
        rd_reg(3'd0, b); chk("R1 ctrl", {8'h0, b}, 16'h0000);
        rd16(3'd2, v);   chk("R1 cmp", v, 16'hFFFF);
        rd16(3'd4, v);   chk("R1 cap0", v, 16'h0000);
        rd_reg(3'd1, b); chk("R1 reload", {8'h0, b}, 16'h0000);

        // keep the compare value out of the way of the count tests
        wr_reg(3'd2, 8'h00); wr_reg(3'd3, 8'h80);

        // R2 up, reload 0, 5 cycles; R4 capture while stopped
        run_count(8'd0, 5, UDC);
        capture(0);
        rd16(3'd4, v); chk("R2/R4 up r=0 cap0", v, 16'd5);

        // R2 prescaler reload 3, 10 cycles -> 2 steps
        run_count(8'd3, 10, UDC);
        capture(1);
        rd16(3'd6, v); chk("R2 reload=3 cap1", v, 16'd2);

        // R11 / R2 global enable low
        glob_en = 1'b0;
        wr_reg(3'd0, CEN | UDC);
        rd_reg(3'd0, b); chk("R11 run bit low with glob off", {8'h0, b}, 16'h008C);
        run_count(8'd0, 6, UDC);
        capture(1);
        rd16(3'd6, v); chk("R2 glob off no count", v, 16'd0);
        glob_en = 1'b1;

        // R9 underflow, R10 flag
        exp_q.push_back(3'b001);
        run_count(8'd0, 3, 8'h00);
        capture(0);
        rd_reg(3'd0, b); chk("R10 flag set", {8'h0, b}, 16'h0002);
        rd_reg(3'd0, b); chk("R10 flag cleared by read", {8'h0, b}, 16'h0000);
        rd16(3'd4, v);   chk("R9 down count cap0", v, 16'hFFFD);

        // R8 hardware direction override
        hw_valid = 1'b1; hw_up = 1'b1;
        run_count(8'd0, 4, 8'h00);
        rd_reg(3'd0, b); chk("R8 dir status hw up", {8'h0, b}, 16'h0004);
        hw_valid = 1'b0;
        rd_reg(3'd0, b); chk("R8 dir status sw down", {8'h0, b}, 16'h0000);
        capture(1);
        rd16(3'd6, v); chk("R8 hw up count", v, 16'd4);

        // R7 software clear while stopped, reads 0, no irq
        wr_reg(3'd0, CCL);
        rd_reg(3'd0, b); chk("R7 clear bit reads 0", {8'h0, b}, 16'h0000);
        capture(1);
        rd16(3'd6, v); chk("R7 counter cleared", v, 16'd0);

        // R5 clear on capture
        wr_reg(3'd1, 8'd0);
        wr_reg(3'd0, CEN | CCL | CCP | UDC);
        repeat (4) @(negedge clk);
        exp_q.push_back(3'b100);
        trig[0] = 1'b1;
        @(negedge clk);
        trig[0] = 1'b0;
        repeat (2) @(negedge clk);
        wr_reg(3'd0, UDC);
        capture(1);
        rd16(3'd4, v); chk("R5 captured before clear", v, 16'd4);
        rd16(3'd6, v); chk("R5 restart from zero", v, 16'd3);

        // R6 clear on compare, compare = 3, period 4
        wr_reg(3'd2, 8'd3); wr_reg(3'd3, 8'd0);
        exp_q.push_back(3'b010);
        exp_q.push_back(3'b010);
        run_count(8'd0, 10, CCMP | UDC);
        capture(1);
        rd16(3'd6, v); chk("R6 clear on compare", v, 16'd2);
        wr_reg(3'd2, 8'h00); wr_reg(3'd3, 8'h80);

        // R9 overflow up, R3 resume without reload
        exp_q.push_back(3'b001);
        run_count(8'd0, 1, 8'h00);
        exp_q.push_back(3'b001);
        wr_reg(3'd0, CEN | UDC);
        wr_reg(3'd0, UDC);
        capture(1);
        rd16(3'd6, v); chk("R9 overflow to zero", v, 16'd0);
        wr_reg(3'd0, CEN | UDC);
        repeat (2) @(negedge clk);
        wr_reg(3'd0, UDC);
        capture(1);
        rd16(3'd6, v); chk("R3 resumed count", v, 16'd3);

        // R7 clear beats a due step while running
        wr_reg(3'd0, CEN | CCL | UDC);
        repeat (4) @(negedge clk);
        wr_reg(3'd0, CEN | CCL | UDC);
        @(negedge clk);
        wr_reg(3'd0, UDC);
        capture(1);
        rd16(3'd6, v); chk("R7 clear wins over step", v, 16'd2);

        // R12 / R11 control readback while running
        wr_reg(3'd0, 8'hE8);
        rd_reg(3'd0, b); chk("R12 ctrl readback", {8'h0, b}, 16'h00ED);
        wr_reg(3'd0, 8'h00);
        rd_reg(3'd1, b); chk("R12 reload readback", {8'h0, b}, 16'h0000);

        repeat (3) @(negedge clk);
        chk("R4/R6/R9 scoreboard drained", 16'(exp_q.size()), 16'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule